// File: doc/BRIEF.md
# Ethernet Transmit Status Tracker

This block keeps the completion status of a half-duplex Ethernet transmitter and owns its transmit-enable bit. The transmit engine reports events to it as one-cycle strobes: frame start and end, end of preamble, each collision, a data underrun, the interframe-gap start and the broadcast nature of the frame. It also receives a byte-time tick and the deferral and carrier-sense levels. From these it builds a 16-bit status word. Fatal conditions (underrun, late collision, lost carrier) stop the transmitter by clearing transmit enable. Their flags stay latched until software writes transmit enable back to 1. Informational flags are cleared per frame.

Each finished frame produces exactly one snapshot strobe with a copy of the status word. The packet-memory side stores that copy as the first word of the frame's buffer. Four saturating 4-bit event counters record completed frames that were deferred, excessively deferred, had one collision, or had several collisions. A flag reports when any of them fills, and reading the counters clears both the counters and that flag. An active-low link pin is synchronised and its inverse is reported, with an interrupt pulse on every change.

Top module: `eth_txstat_tracker`

## Requirements
- R1: After reset, status, snap_word, ctr_word, tx_enable, jam, snap_valid and link_irq are all 0 (link_n held at 1).
- R2: An underrun strobe sets status bit 8 and forces tx_enable to 0 at the next edge. Bit 8 stays set until a write of txen_wdata=1, which clears it and sets tx_enable (status bit 11 mirrors tx_enable).
- R3: A collision strobe when at least LATE_BYTES byte ticks have been counted since frame start sets status bit 7, pulses jam for one cycle and clears tx_enable. With fewer ticks it does neither. Bit 7 clears on an enable write of 1.
- R4: preamble_end with mon_carrier_en=1 and carrier_sense=0 sets status bit 6 and clears tx_enable. With mon_carrier_en=0 or carrier present it has no effect.
- R5: Status bit 5 sets once more than EXC_DEFER_BYTES byte ticks with defer_active high have accumulated since the previous completed frame. Exactly EXC_DEFER_BYTES ticks leave it clear. It clears in the snapshot cycle.
- R6: Status bit 4 sets if carrier_sense is high in the ifg_start cycle or any of the IFG_CYCLES-1 cycles after it. Carrier at offset IFG_CYCLES or later has no effect. Bit 4 clears in the snapshot cycle.
- R7: Status bit 1 sets on bcast_frame and clears on the next frm_start (a same-cycle bcast_frame wins).
- R8: Status bit 10 equals the inverse of link_n three edges after link_n changes, and link_irq pulses for one cycle in that same cycle.
- R9: ctr_word holds four saturating 4-bit counts of completed frames: [3:0] deferred, [7:4] excessively deferred, [11:8] single collision, [15:12] multiple collisions. Status bit 9 sets one cycle after any count reaches 15. ctr_rd clears all counts and bit 9 at the next edge, with priority over increments.
- R10: A write of txen_wdata=0 during a frame keeps tx_enable at 1 until the frame's frm_end edge. Outside a frame it clears tx_enable at once.
- R11: For each frm_end, snap_valid is high for exactly one cycle, two edges later. snap_word carries the status at that point: bit 0 set if the frame had no fatal event, bit 2 for exactly one collision, bit 3 for two or more.
- R12: When a fatal event and an enable write of 1 fall in the same cycle, the fatal event wins: tx_enable ends 0 and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start-of-frame strobe |
| frm_end | input | 1 | End-of-frame strobe |
| preamble_end | input | 1 | End-of-preamble strobe |
| byte_tick | input | 1 | One pulse per byte time |
| collision | input | 1 | Collision strobe |
| underrun | input | 1 | Transmit data underrun strobe |
| defer_active | input | 1 | High while transmission is deferring |
| carrier_sense | input | 1 | Carrier sense level |
| ifg_start | input | 1 | Interframe gap start strobe |
| bcast_frame | input | 1 | Current frame is broadcast |
| mon_carrier_en | input | 1 | Enables lost-carrier monitoring |
| link_n | input | 1 | Active-low link pin (asynchronous) |
| txen_wr | input | 1 | Write strobe for transmit enable |
| txen_wdata | input | 1 | Value written to transmit enable |
| ctr_rd | input | 1 | Counter register read strobe |
| tx_enable | output | 1 | Transmit enable |
| jam | output | 1 | Jam request pulse on late collision |
| status | output | 16 | Live status word |
| snap_valid | output | 1 | Snapshot strobe, one per frame |
| snap_word | output | 16 | Status copy for packet memory |
| ctr_word | output | 16 | Event counter register |
| link_irq | output | 1 | Link change interrupt pulse |

## Verification
Two functions can land on the same cycle: a software enable write and a fatal transmit event that clears the same enable bit. The bench drives an underrun strobe together with a write of 1 and judges the port outcome: enable must stay 0 and the underrun flag must stay set. A second overlap is a counter read against a snapshot-cycle increment, where the read must win. The bench also sweeps the carrier offset across the interframe window edge and the byte count across the late-collision and excessive-deferral thresholds.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int unsigned STAT_W      = 16;
  localparam int unsigned ST_TXOK     = 0;
  localparam int unsigned ST_BCAST    = 1;
  localparam int unsigned ST_COL1     = 2;
  localparam int unsigned ST_COLN     = 3;
  localparam int unsigned ST_DEFER    = 4;
  localparam int unsigned ST_EXCDEF   = 5;
  localparam int unsigned ST_LOSTCRS  = 6;
  localparam int unsigned ST_LATECOL  = 7;
  localparam int unsigned ST_UNDERRUN = 8;
  localparam int unsigned ST_CTRROLL  = 9;
  localparam int unsigned ST_LINK     = 10;
  localparam int unsigned ST_TXEN     = 11;
  localparam int unsigned NUM_EVT     = 4;
  // event counter slots inside the counter register
  localparam int unsigned EV_DEFER    = 0;
  localparam int unsigned EV_EXCDEF   = 1;
  localparam int unsigned EV_COL1     = 2;
  localparam int unsigned EV_COLN     = 3;
endpackage

// File: rtl/txs_sat_counter.sv
module txs_sat_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);
  assign full = &cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !full) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txs_ifg_window.sv
module txs_ifg_window #(
  parameter int unsigned CYC = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic carrier,
  output logic hit
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] left;

  // window covers the start cycle plus CYC-1 following cycles
  assign hit = carrier && (start || (left != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (start) begin
      left <= CW'(CYC - 1);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/txs_link_sync.sv
module txs_link_sync (
  input  logic clk,
  input  logic rst,
  input  logic link_n,
  output logic link_ok,
  output logic link_chg
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= 1'b1;
      s2       <= 1'b1;
      link_ok  <= 1'b0;
      link_chg <= 1'b0;
    end else begin
      s1       <= link_n;
      s2       <= s1;
      link_ok  <= ~s2;
      link_chg <= (~s2) != link_ok;
    end
  end
endmodule

// File: rtl/eth_txstat_tracker.sv
module eth_txstat_tracker
  import txs_pkg::*;
#(
  parameter int unsigned LATE_BYTES      = 64,
  parameter int unsigned EXC_DEFER_BYTES = 3036,
  parameter int unsigned IFG_CYCLES      = 160,
  parameter int unsigned EVT_W           = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frm_start,
  input  logic                     frm_end,
  input  logic                     preamble_end,
  input  logic                     byte_tick,
  input  logic                     collision,
  input  logic                     underrun,
  input  logic                     defer_active,
  input  logic                     carrier_sense,
  input  logic                     ifg_start,
  input  logic                     bcast_frame,
  input  logic                     mon_carrier_en,
  input  logic                     link_n,
  input  logic                     txen_wr,
  input  logic                     txen_wdata,
  input  logic                     ctr_rd,
  output logic                     tx_enable,
  output logic                     jam,
  output logic [STAT_W-1:0]        status,
  output logic                     snap_valid,
  output logic [STAT_W-1:0]        snap_word,
  output logic [NUM_EVT*EVT_W-1:0] ctr_word,
  output logic                     link_irq
);
  localparam int unsigned BYTE_W = $clog2(LATE_BYTES + 1);
  localparam int unsigned DEF_W  = $clog2(EXC_DEFER_BYTES + 2);

  // frame byte position and accumulated deferral
  logic [BYTE_W-1:0] byte_cnt;
  logic              byte_full;
  logic [DEF_W-1:0]  def_cnt;
  logic              def_full;
  logic              done_q;

  txs_sat_counter #(.W(BYTE_W)) u_bytes (
    .clk(clk), .rst(rst), .clr(frm_start), .inc(byte_tick),
    .cnt(byte_cnt), .full(byte_full)
  );

  txs_sat_counter #(.W(DEF_W)) u_defer (
    .clk(clk), .rst(rst), .clr(done_q), .inc(byte_tick && defer_active),
    .cnt(def_cnt), .full(def_full)
  );

  logic ifg_hit;
  txs_ifg_window #(.CYC(IFG_CYCLES)) u_ifg (
    .clk(clk), .rst(rst), .start(ifg_start), .carrier(carrier_sense),
    .hit(ifg_hit)
  );

  logic link_ok;
  txs_link_sync u_link (
    .clk(clk), .rst(rst), .link_n(link_n),
    .link_ok(link_ok), .link_chg(link_irq)
  );

  // event decode
  logic late_hit, lost_hit, fatal, en_set, en_clr, exc_hit;
  assign late_hit = collision && (byte_full || (byte_cnt >= BYTE_W'(LATE_BYTES)));
  assign lost_hit = preamble_end && mon_carrier_en && !carrier_sense;
  assign fatal    = underrun || late_hit || lost_hit;
  assign en_set   = txen_wr && txen_wdata;
  assign en_clr   = txen_wr && !txen_wdata;
  assign exc_hit  = !done_q && (def_full || (def_cnt > DEF_W'(EXC_DEFER_BYTES)));

  // status flags
  logic f_underrun, f_late, f_lost, f_txok, f_col1, f_coln;
  logic f_bcast, f_defer, f_exc, f_roll;
  logic in_frame, stop_pend, frame_err;
  logic [1:0] col_n;

  // per-frame event counters
  logic [NUM_EVT-1:0] ev_inc, ev_full;
  assign ev_inc[EV_DEFER]  = done_q && f_defer;
  assign ev_inc[EV_EXCDEF] = done_q && f_exc;
  assign ev_inc[EV_COL1]   = done_q && f_col1;
  assign ev_inc[EV_COLN]   = done_q && f_coln;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    txs_sat_counter #(.W(EVT_W)) u_evt (
      .clk(clk), .rst(rst), .clr(ctr_rd), .inc(ev_inc[i]),
      .cnt(ctr_word[i*EVT_W +: EVT_W]), .full(ev_full[i])
    );
  end

  always_comb begin
    status              = '0;
    status[ST_TXOK]     = f_txok;
    status[ST_BCAST]    = f_bcast;
    status[ST_COL1]     = f_col1;
    status[ST_COLN]     = f_coln;
    status[ST_DEFER]    = f_defer;
    status[ST_EXCDEF]   = f_exc;
    status[ST_LOSTCRS]  = f_lost;
    status[ST_LATECOL]  = f_late;
    status[ST_UNDERRUN] = f_underrun;
    status[ST_CTRROLL]  = f_roll;
    status[ST_LINK]     = link_ok;
    status[ST_TXEN]     = tx_enable;
  end

  // transmit enable: fatal events win, software stop waits for frame end
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_enable <= 1'b0;
      stop_pend <= 1'b0;
    end else if (fatal) begin
      tx_enable <= 1'b0;
      stop_pend <= 1'b0;
    end else if (en_set) begin
      tx_enable <= 1'b1;
      stop_pend <= 1'b0;
    end else if (en_clr) begin
      if (in_frame && !frm_end) begin
        stop_pend <= 1'b1;
      end else begin
        tx_enable <= 1'b0;
      end
    end else if (stop_pend && frm_end) begin
      tx_enable <= 1'b0;
      stop_pend <= 1'b0;
    end
  end

  // latched fatal flags: cleared only by an enable write of 1
  always_ff @(posedge clk) begin
    if (rst) begin
      f_underrun <= 1'b0;
      f_late     <= 1'b0;
      f_lost     <= 1'b0;
    end else begin
      if (underrun)    f_underrun <= 1'b1;
      else if (en_set) f_underrun <= 1'b0;
      if (late_hit)    f_late     <= 1'b1;
      else if (en_set) f_late     <= 1'b0;
      if (lost_hit)    f_lost     <= 1'b1;
      else if (en_set) f_lost     <= 1'b0;
    end
  end

  // per-frame tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      frame_err <= 1'b0;
      col_n     <= '0;
      f_txok    <= 1'b0;
      f_col1    <= 1'b0;
      f_coln    <= 1'b0;
      f_bcast   <= 1'b0;
      f_defer   <= 1'b0;
      f_exc     <= 1'b0;
      f_roll    <= 1'b0;
      done_q    <= 1'b0;
      jam       <= 1'b0;
    end else begin
      done_q <= frm_end;
      jam    <= late_hit;

      if (frm_start)    in_frame <= 1'b1;
      else if (frm_end) in_frame <= 1'b0;

      if (frm_start)  frame_err <= fatal;
      else if (fatal) frame_err <= 1'b1;

      if (frm_start)                   col_n <= '0;
      else if (collision && col_n != 2'd3) col_n <= col_n + 2'd1;

      if (frm_start) begin
        f_txok <= 1'b0;
        f_col1 <= 1'b0;
        f_coln <= 1'b0;
      end else if (frm_end) begin
        f_txok <= !(frame_err || fatal);
        f_col1 <= (col_n == 2'd1);
        f_coln <= (col_n >= 2'd2);
      end

      if (bcast_frame)    f_bcast <= 1'b1;
      else if (frm_start) f_bcast <= 1'b0;

      if (ifg_hit)     f_defer <= 1'b1;
      else if (done_q) f_defer <= 1'b0;

      if (exc_hit)     f_exc <= 1'b1;
      else if (done_q) f_exc <= 1'b0;

      if (ctr_rd)        f_roll <= 1'b0;
      else if (|ev_full) f_roll <= 1'b1;
    end
  end

  // one status copy per completed frame
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_valid <= 1'b0;
      snap_word  <= '0;
    end else begin
      snap_valid <= done_q;
      if (done_q) snap_word <= status;
    end
  end
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic        clk,
  input logic        rst,
  input logic        underrun,
  input logic        txen_wr,
  input logic        txen_wdata,
  input logic        frm_end,
  input logic        ctr_rd,
  input logic        tx_enable,
  input logic        jam,
  input logic [15:0] status,
  input logic        snap_valid,
  input logic [15:0] ctr_word,
  input logic        link_irq
);
  // R2
  underrun_stop_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> (!tx_enable && status[8]));
  // R3
  jam_off_chk: assert property (@(posedge clk) disable iff (rst)
    jam |-> !tx_enable);
  // R11
  snap_lat_chk: assert property (@(posedge clk) disable iff (rst)
    snap_valid |-> $past(frm_end, 2));
  // R11
  snap_once_chk: assert property (@(posedge clk) disable iff (rst)
    snap_valid |=> !snap_valid);
  // R12
  fatal_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && txen_wr && txen_wdata) |=> (!tx_enable && status[8]));
  // R8
  irq_chg_chk: assert property (@(posedge clk) disable iff (rst)
    link_irq |-> (status[10] != $past(status[10])));
  // R9
  ctr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctr_rd |=> (ctr_word == 16'h0 && !status[9]));
endmodule

bind eth_txstat_tracker txs_checker u_txs_chk (
  .clk(clk), .rst(rst), .underrun(underrun), .txen_wr(txen_wr),
  .txen_wdata(txen_wdata), .frm_end(frm_end), .ctr_rd(ctr_rd),
  .tx_enable(tx_enable), .jam(jam), .status(status),
  .snap_valid(snap_valid), .ctr_word(ctr_word), .link_irq(link_irq)
);

// File: tb/sim_eth_txstat_tracker.sv
`timescale 1ns/1ps
module sim_eth_txstat_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 0, frm_end = 0, preamble_end = 0, byte_tick = 0;
  logic collision = 0, underrun = 0, defer_active = 0, carrier_sense = 0;
  logic ifg_start = 0, bcast_frame = 0, mon_carrier_en = 0, link_n = 1;
  logic txen_wr = 0, txen_wdata = 0, ctr_rd = 0;
  logic tx_enable, jam, snap_valid, link_irq;
  logic [15:0] status, snap_word, ctr_word;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eth_txstat_tracker u0 (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
    .preamble_end(preamble_end), .byte_tick(byte_tick), .collision(collision),
    .underrun(underrun), .defer_active(defer_active),
    .carrier_sense(carrier_sense), .ifg_start(ifg_start),
    .bcast_frame(bcast_frame), .mon_carrier_en(mon_carrier_en),
    .link_n(link_n), .txen_wr(txen_wr), .txen_wdata(txen_wdata),
    .ctr_rd(ctr_rd), .tx_enable(tx_enable), .jam(jam), .status(status),
    .snap_valid(snap_valid), .snap_word(snap_word), .ctr_word(ctr_word),
    .link_irq(link_irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic v);
    txen_wr = 1'b1;
    txen_wdata = v;
    step();
    txen_wr = 1'b0;
    txen_wdata = 1'b0;
  endtask

  task automatic run_frame(input logic bc, input int ncoll, output logic [15:0] sw);
    frm_start = 1'b1;
    bcast_frame = bc;
    step();
    frm_start = 1'b0;
    bcast_frame = 1'b0;
    for (int i = 0; i < ncoll; i++) begin
      collision = 1'b1;
      step();
      collision = 1'b0;
      step();
    end
    frm_end = 1'b1;
    step();
    frm_end = 1'b0;
    check("R11 no early snapshot", 32'(snap_valid), 32'd0);
    step();
    check("R11 snapshot strobe", 32'(snap_valid), 32'd1);
    sw = snap_word;
    step();
    check("R11 single snapshot", 32'(snap_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] sw;
    int ks [5] = '{0, 1, 159, 160, 200};
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    check("R1 status", 32'(status), 32'h0);
    check("R1 tx_enable", 32'(tx_enable), 32'd0);
    check("R1 outputs", 32'({jam, snap_valid, link_irq}), 32'd0);
    check("R1 ctr_word", 32'(ctr_word), 32'h0);

    set_en(1'b1);
    check("R2 enable set", 32'({tx_enable, status[11]}), 32'd3);

    // R2 underrun latches and stops
    underrun = 1'b1;
    step();
    underrun = 1'b0;
    check("R2 underrun stop", 32'({tx_enable, status[8]}), 32'd1);
    repeat (4) step();
    check("R2 flag held", 32'(status[8]), 32'd1);
    set_en(1'b1);
    check("R2 cleared by enable", 32'({tx_enable, status[8]}), 32'd2);

    // R12 same-cycle fatal event and enable write
    underrun = 1'b1;
    txen_wr = 1'b1;
    txen_wdata = 1'b1;
    step();
    underrun = 1'b0;
    txen_wr = 1'b0;
    txen_wdata = 1'b0;
    check("R12 fatal wins", 32'({tx_enable, status[8]}), 32'd1);
    set_en(1'b1);

    // R3 late collision threshold
    frm_start = 1'b1;
    step();
    frm_start = 1'b0;
    byte_tick = 1'b1;
    repeat (63) step();
    byte_tick = 1'b0;
    collision = 1'b1;
    step();
    collision = 1'b0;
    check("R3 early collision", 32'({status[7], tx_enable, jam}), 32'b010);
    byte_tick = 1'b1;
    step();
    byte_tick = 1'b0;
    collision = 1'b1;
    step();
    collision = 1'b0;
    check("R3 late collision", 32'({status[7], tx_enable, jam}), 32'b101);
    step();
    check("R3 jam pulse ends", 32'(jam), 32'd0);
    frm_end = 1'b1;
    step();
    frm_end = 1'b0;
    step();
    check("R11 snapshot late frame", 32'({snap_valid, snap_word}), 32'h10088);
    check("R9 multi collision count", 32'(ctr_word), 32'h1000);
    step();
    set_en(1'b1);
    check("R3 cleared by enable", 32'({status[7], tx_enable}), 32'b01);

    // R4 lost carrier
    preamble_end = 1'b1;
    step();
    preamble_end = 1'b0;
    check("R4 monitor off", 32'({status[6], tx_enable}), 32'b01);
    mon_carrier_en = 1'b1;
    preamble_end = 1'b1;
    carrier_sense = 1'b1;
    step();
    carrier_sense = 1'b0;
    preamble_end = 1'b0;
    check("R4 carrier present", 32'({status[6], tx_enable}), 32'b01);
    preamble_end = 1'b1;
    step();
    preamble_end = 1'b0;
    mon_carrier_en = 1'b0;
    check("R4 lost carrier", 32'({status[6], tx_enable}), 32'b10);
    set_en(1'b1);
    check("R4 cleared by enable", 32'({status[6], tx_enable}), 32'b01);

    // R6 interframe window sweep
    foreach (ks[n]) begin
      int k = ks[n];
      logic exp = (k < 160);
      ifg_start = 1'b1;
      carrier_sense = (k == 0);
      step();
      ifg_start = 1'b0;
      carrier_sense = 1'b0;
      for (int j = 1; j <= k; j++) begin
        carrier_sense = (j == k);
        step();
        carrier_sense = 1'b0;
      end
      step();
      check($sformatf("R6 deferred at offset %0d", k), 32'(status[4]), 32'(exp));
      run_frame(1'b0, 0, sw);
      check("R6 snapshot", 32'(sw), 32'h0801 | (32'(exp) << 4));
      check("R6 cleared after snapshot", 32'(status[4]), 32'd0);
    end

    // R7 broadcast
    run_frame(1'b1, 0, sw);
    check("R7 broadcast snapshot", 32'(sw), 32'h0803);
    check("R7 flag held", 32'(status[1]), 32'd1);
    frm_start = 1'b1;
    step();
    frm_start = 1'b0;
    check("R7 cleared at start", 32'(status[1]), 32'd0);
    frm_end = 1'b1;
    step();
    frm_end = 1'b0;
    repeat (2) step();

    // R5 excessive deferral threshold
    defer_active = 1'b1;
    byte_tick = 1'b1;
    repeat (3036) step();
    defer_active = 1'b0;
    byte_tick = 1'b0;
    step();
    check("R5 at limit", 32'(status[5]), 32'd0);
    defer_active = 1'b1;
    byte_tick = 1'b1;
    step();
    defer_active = 1'b0;
    byte_tick = 1'b0;
    step();
    check("R5 over limit", 32'(status[5]), 32'd1);
    run_frame(1'b0, 0, sw);
    check("R5 snapshot", 32'(sw), 32'h0821);
    check("R5 cleared after snapshot", 32'(status[5]), 32'd0);

    // R10 graceful stop
    frm_start = 1'b1;
    step();
    frm_start = 1'b0;
    set_en(1'b0);
    check("R10 held during frame", 32'(tx_enable), 32'd1);
    repeat (3) step();
    check("R10 still held", 32'(tx_enable), 32'd1);
    frm_end = 1'b1;
    step();
    frm_end = 1'b0;
    check("R10 off at frame end", 32'(tx_enable), 32'd0);
    step();
    check("R11 snapshot after stop", 32'({snap_valid, snap_word}), 32'h10001);
    step();
    set_en(1'b1);
    set_en(1'b0);
    check("R10 immediate outside frame", 32'(tx_enable), 32'd0);
    set_en(1'b1);

    // R9 counters, saturation and rollover
    ctr_rd = 1'b1;
    step();
    ctr_rd = 1'b0;
    check("R9 read clears", 32'({status[9], ctr_word}), 32'h0);
    for (int f = 1; f <= 16; f++) begin
      run_frame(1'b0, 1, sw);
      if (f == 1) check("R11 single collision snapshot", 32'(sw), 32'h0805);
      if (f == 16) check("R9 rollover in snapshot", 32'(sw), 32'h0A05);
      check($sformatf("R9 single count frame %0d", f), 32'(ctr_word),
            32'((f > 15 ? 15 : f) << 8));
      if (f == 15) check("R9 rollover flag", 32'(status[9]), 32'd1);
    end
    ctr_rd = 1'b1;
    step();
    ctr_rd = 1'b0;
    check("R9 read clears all", 32'({status[9], ctr_word}), 32'h0);

    // R8 link synchroniser and interrupt
    link_n = 1'b0;
    repeat (2) step();
    check("R8 latency", 32'({status[10], link_irq}), 32'b00);
    step();
    check("R8 link up", 32'({status[10], link_irq}), 32'b11);
    step();
    check("R8 irq pulse", 32'({status[10], link_irq}), 32'b10);
    link_n = 1'b1;
    repeat (3) step();
    check("R8 link down", 32'({status[10], link_irq}), 32'b01);
    step();
    check("R8 irq ends", 32'(link_irq), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule